// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Mode

The block is one timer channel that counts input clocks through a 16-bit divider and a 16-bit period counter. Both values are loaded from a single 32-bit count register. A mode register selects one-shot or free-running operation, enables the counter and the interrupt, and can switch the channel into watchdog duty. Every time the programmed interval runs out, a sticky event flag is raised, and that flag drives the interrupt output when interrupts are enabled.

In watchdog duty the same counter becomes a deadline. Software keeps it alive by writing a fixed key byte into the top byte lane of the mode register. If no key arrives before the interval runs out, a reset request output goes high and stays high until the block itself is reset. While in this duty the interrupt path is masked, and the channel can only be stopped by clearing the enable and the watchdog bits in the same write. Registers are written through byte-lane strobes and read back combinationally. The asynchronous active-low reset is synchronised inside the block before use.

Top module: `wdt_timer`

## Requirements
- R1: After reset the mode register (address 0), count register (address 1) and status register (address 2) read 0, and irq_o and wdt_rst_o are low.
- R2: The count register holds the divider value in bits [31:16] and the period value in bits [15:0], written per byte lane under wr_strb, and any write to it restarts the divider and the period counter from the new values.
- R3: With divider value D and period value P (a value of 0 meaning 65536 for either), the interval ends on the D*P-th clock edge after the restart, and each interval end sets status bit 0.
- R4: With mode bit 10 set the timer reloads and ends an interval every D*P edges; with it clear the timer ends one interval and then clears mode bit 12.
- R5: Mode bit 12 enables counting; while it is clear no interval ends, and its 0-to-1 change restarts the divider and counter from the full interval.
- R6: irq_o is high when status bit 0 and mode bit 8 are both set and mode bit 15 is clear; writing 1 to status bit 0 clears it, unless an interval ends on the same edge.
- R7: While mode bit 15 is set, mode bit 8 reads 0 and cannot be set, and irq_o stays low.
- R8: While mode bit 15 is set, a write of 0xA5 on byte lane 3 (bits [31:24]) of the mode register restarts the full interval and changes no mode bit; any other value on that lane has no effect.
- R9: When an interval ends in watchdog mode, wdt_rst_o goes high on that edge, mode bit 12 clears, and wdt_rst_o stays high until reset.
- R10: While mode bit 15 is set, a lane-1 mode write changes bits 12 and 15 only if it clears both; any other lane-1 write leaves them as they are. Clearing both disarms the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 count, 2 status |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte-lane enables for the write |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Interval interrupt |
| wdt_rst_o | output | 1 | Latched watchdog reset request |

## Verification
The bench drives a divider value of 0 so that the 65536-way division is used. A design that treated 0 as divide-by-one would end the interval about 65000 cycles early. One-shot expiry is checked for the enable bit dropping exactly on the expiry edge. A design that kept running would raise the flag a second time. In watchdog duty the bench sends the key, sends a wrong key byte, and tries to clear the enable alone. A design that accepted the wrong key, let the enable be cleared by itself, or failed to hold the reset request would drive wdt_rst_o at the wrong time. A flag clear is also issued on the same edge as an expiry, where a design that gave the clear priority would lose an event.

// File: rtl/wdt_timer_pkg.sv
package wdt_timer_pkg;
  localparam int          MODE_IRQ_BIT  = 8;
  localparam int          MODE_CONT_BIT = 10;
  localparam int          MODE_EN_BIT   = 12;
  localparam int          MODE_WDT_BIT  = 15;
  localparam logic [7:0]  KEEPALIVE_KEY = 8'hA5;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_COUNT = 2'd1,
    REG_STAT  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] pre_q, pre_d;

  assign tick = run && (pre_q == '0);

  always_comb begin
    pre_d = pre_q;
    if (restart)      pre_d = reload;
    else if (tick)    pre_d = reload;
    else if (run)     pre_d = pre_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: the divider steps down by one per running clock
  a_r3_pre_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    run && !restart && (pre_q != '0) |=> pre_q == $past(pre_q) - 1'b1);
endmodule

// File: rtl/tmr_period.sv
module tmr_period #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] reload,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;

  assign expire = tick && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = reload;
    else if (expire)  cnt_d = reload;
    else if (tick)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: an interval end reloads the full period
  a_r4_reload_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !restart |=> cnt_q == $past(reload));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_timer_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int PER_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_strb,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_o,
  output logic        wdt_rst_o
);
  localparam int LANES   = 4;
  localparam int PRE_LSB = 16;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             irq_en_q, cont_q, en_q, wdt_q, flag_q, rst_q;
  logic             irq_en_d, cont_d, en_d, wdt_d, flag_d, rst_d;
  logic [PRE_W-1:0] psc_q, psc_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [31:0]      cnt_word, cnt_merge;
  logic             wr_mode, wr_count, wr_stat, keepalive, restart;
  logic             tick, expire, disarm_req;

  assign wr_mode  = wr_en && (wr_addr == REG_MODE);
  assign wr_count = wr_en && (wr_addr == REG_COUNT);
  assign wr_stat  = wr_en && (wr_addr == REG_STAT);
  assign keepalive = wr_mode && wr_strb[3] && (wr_data[31:24] == KEEPALIVE_KEY) && wdt_q;
  assign disarm_req = !wr_data[MODE_EN_BIT] && !wr_data[MODE_WDT_BIT];

  always_comb begin
    cnt_word = '0;
    cnt_word[PRE_LSB +: PRE_W] = psc_q;
    cnt_word[0 +: PER_W]       = per_q;
    cnt_merge = cnt_word;
    for (int i = 0; i < LANES; i++)
      if (wr_strb[i]) cnt_merge[i*8 +: 8] = wr_data[i*8 +: 8];
  end

  // next-state of the register file
  always_comb begin
    irq_en_d = irq_en_q;
    cont_d   = cont_q;
    en_d     = en_q;
    wdt_d    = wdt_q;
    flag_d   = flag_q;
    rst_d    = rst_q;
    psc_d    = psc_q;
    per_d    = per_q;

    if (expire) begin
      flag_d = 1'b1;
      if (wdt_q) begin
        rst_d = 1'b1;
        en_d  = 1'b0;
      end else if (!cont_q) begin
        en_d  = 1'b0;
      end
    end

    if (wr_stat && wr_strb[0] && wr_data[0] && !expire) flag_d = 1'b0;

    if (wr_count) begin
      psc_d = cnt_merge[PRE_LSB +: PRE_W];
      per_d = cnt_merge[0 +: PER_W];
    end

    if (wr_mode && wr_strb[1]) begin
      irq_en_d = wr_data[MODE_IRQ_BIT];
      cont_d   = wr_data[MODE_CONT_BIT];
      if (!wdt_q || disarm_req) begin
        en_d  = wr_data[MODE_EN_BIT];
        wdt_d = wr_data[MODE_WDT_BIT];
      end
    end

    if (wdt_d) irq_en_d = 1'b0;
  end

  assign restart = wr_count || keepalive || (en_d && !en_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_en_q <= 1'b0;
      cont_q   <= 1'b0;
      en_q     <= 1'b0;
      wdt_q    <= 1'b0;
      flag_q   <= 1'b0;
      rst_q    <= 1'b0;
      psc_q    <= '0;
      per_q    <= '0;
    end else begin
      irq_en_q <= irq_en_d;
      cont_q   <= cont_d;
      en_q     <= en_d;
      wdt_q    <= wdt_d;
      flag_q   <= flag_d;
      rst_q    <= rst_d;
      psc_q    <= psc_d;
      per_q    <= per_d;
    end
  end

  tmr_prescale #(.W(PRE_W)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (en_q),
    .restart (restart),
    .reload  (psc_d - 1'b1),
    .tick    (tick)
  );

  tmr_period #(.W(PER_W)) u_period (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .restart (restart),
    .reload  (per_d - 1'b1),
    .expire  (expire)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_MODE: begin
        rd_data[MODE_IRQ_BIT]  = irq_en_q;
        rd_data[MODE_CONT_BIT] = cont_q;
        rd_data[MODE_EN_BIT]   = en_q;
        rd_data[MODE_WDT_BIT]  = wdt_q;
      end
      REG_COUNT: rd_data = cnt_word;
      REG_STAT:  rd_data[0] = flag_q;
      default:   rd_data = '0;
    endcase
  end

  assign irq_o     = flag_q && irq_en_q && !wdt_q;
  assign wdt_rst_o = rst_q;

  // R9: the reset request never drops without a block reset
  a_r9_rst_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_q |=> rst_q);

  // R7: interrupt enable is never held while in watchdog duty
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_q |-> !irq_en_q);

  // R8: a key-only write leaves every mode bit unchanged
  a_r8_key_keeps_mode: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_mode && (wr_strb == 4'b1000) && !expire
    |=> $stable(en_q) && $stable(wdt_q) && $stable(cont_q) && $stable(irq_en_q));

  // R4: one-shot expiry drops the enable
  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_int_n)
    expire && !cont_q && !(wr_mode && wr_strb[1]) |=> !en_q);

  // R10: an armed watchdog stays armed unless both bits are cleared together
  a_r10_wdt_lock: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_q && en_q && !expire && !(wr_mode && wr_strb[1] && disarm_req)
    |=> en_q && wdt_q);
endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_strb;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq_o;
  logic        wdt_rst_o;

  always #4 clk = ~clk;

  wdt_timer u_wdt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  int    n_vec  = 0;
  int    n_miss = 0;
  int    cycles = 0;
  string cur_req = "R1";
  logic [1:0] rd_sel = 2'd0;

  // reference state
  bit          m_irq, m_cont, m_en, m_wdt, m_flag, m_rst;
  logic [15:0] m_psc, m_per;
  longint      m_rem;

  function automatic longint span(input logic [15:0] p, input logic [15:0] d);
    longint pp, dd;
    pp = (p == 16'd0) ? 65536 : longint'(p);
    dd = (d == 16'd0) ? 65536 : longint'(d);
    return pp * dd;
  endfunction

  task automatic model_reset();
    m_irq = 0; m_cont = 0; m_en = 0; m_wdt = 0; m_flag = 0; m_rst = 0;
    m_psc = '0; m_per = '0; m_rem = 0;
  endtask

  task automatic model_edge(input logic we, input logic [1:0] a,
                            input logic [31:0] d, input logic [3:0] s);
    bit n_irq, n_cont, n_en, n_wdt, n_flag, n_rst, ex, rs;
    logic [31:0] cw;
    n_irq = m_irq; n_cont = m_cont; n_en = m_en; n_wdt = m_wdt;
    n_flag = m_flag; n_rst = m_rst; rs = 0;
    ex = m_en && (m_rem == 1);
    if (ex) begin
      n_flag = 1;
      if (m_wdt) begin n_rst = 1; n_en = 0; end
      else if (!m_cont) n_en = 0;
      m_rem = span(m_per, m_psc);
    end else if (m_en) m_rem = m_rem - 1;
    if (we && a == 2'd2 && s[0] && d[0] && !ex) n_flag = 0;
    if (we && a == 2'd1) begin
      cw = {m_psc, m_per};
      for (int i = 0; i < 4; i++) if (s[i]) cw[i*8 +: 8] = d[i*8 +: 8];
      m_psc = cw[31:16]; m_per = cw[15:0]; rs = 1;
    end
    if (we && a == 2'd0) begin
      if (s[1]) begin
        n_irq = d[8]; n_cont = d[10];
        if (!m_wdt || (!d[12] && !d[15])) begin n_en = d[12]; n_wdt = d[15]; end
      end
      if (s[3] && d[31:24] == 8'hA5 && m_wdt) rs = 1;
    end
    if (n_wdt) n_irq = 0;
    if (n_en && !m_en) rs = 1;
    if (rs) m_rem = span(m_per, m_psc);
    m_irq = n_irq; m_cont = n_cont; m_en = n_en; m_wdt = n_wdt;
    m_flag = n_flag; m_rst = n_rst;
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", cur_req, what, cycles, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] e;
    case (rd_sel)
      2'd0: e = (32'(m_irq) << 8) | (32'(m_cont) << 10) | (32'(m_en) << 12) | (32'(m_wdt) << 15);
      2'd1: e = {m_psc, m_per};
      2'd2: e = {31'd0, m_flag};
      default: e = '0;
    endcase
    check("rd_data", rd_data, e);
    check("irq_o (R6 R7)", {31'd0, irq_o}, {31'd0, m_flag && m_irq && !m_wdt});
    check("wdt_rst_o (R9)", {31'd0, wdt_rst_o}, {31'd0, m_rst});
  endtask

  task automatic step(input logic we, input logic [1:0] a,
                      input logic [31:0] d, input logic [3:0] s);
    wr_en = we; wr_addr = a; wr_data = d; wr_strb = s;
    rd_sel = rd_sel + 2'd1;
    rd_addr = rd_sel;
    @(posedge clk);
    cycles++;
    model_edge(we, a, d, s);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0, 4'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 0; wr_addr = 0; wr_data = 0; wr_strb = 0; rd_addr = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  endtask

  initial begin
    while (cycles < 190000) @(posedge clk);
    n_miss++;
    $display("FAIL %s watchdog: run hung at cycle %0d, expected end", cur_req, cycles);
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state on every register and output
    cur_req = "R1";
    idle(6);

    // R2: count layout and byte lanes
    cur_req = "R2";
    step(1, 2'd1, 32'h0003_0005, 4'hF);
    idle(3);
    step(1, 2'd1, 32'hFFFF_0004, 4'h3);
    idle(3);

    // R3 / R6: one-shot with interrupt enabled, divider 3, period 4 -> 12 edges
    cur_req = "R3";
    step(1, 2'd0, 32'h0000_1100, 4'h2);
    idle(16);
    // R6: clear the flag
    cur_req = "R6";
    step(1, 2'd2, 32'h1, 4'h1);
    idle(3);

    // R4: continuous, several intervals, clear colliding with an expiry
    cur_req = "R4";
    step(1, 2'd1, 32'h0002_0003, 4'hF);
    step(1, 2'd0, 32'h0000_1500, 4'h2);
    idle(5);
    cur_req = "R6";
    step(1, 2'd2, 32'h1, 4'h1);
    idle(14);

    // R5: stop mid-interval, then restart from full interval
    cur_req = "R5";
    step(1, 2'd2, 32'h1, 4'h1);
    idle(2);
    step(1, 2'd0, 32'h0000_0500, 4'h2);
    idle(10);
    step(1, 2'd0, 32'h0000_1400, 4'h2);
    idle(14);
    step(1, 2'd0, 32'h0000_0000, 4'h2);

    // R3: divider value 0 means 65536
    cur_req = "R3";
    step(1, 2'd2, 32'h1, 4'h1);
    step(1, 2'd1, 32'h0000_0001, 4'hF);
    step(1, 2'd0, 32'h0000_1100, 4'h2);
    idle(65540);

    // R7 / R8: watchdog armed, divider 2, period 4 -> 8 edges
    do_reset();
    cur_req = "R7";
    idle(4);
    step(1, 2'd1, 32'h0002_0004, 4'hF);
    step(1, 2'd0, 32'h0000_9100, 4'h2);
    step(1, 2'd0, 32'h0000_9100, 4'h2);
    cur_req = "R8";
    for (int k = 0; k < 5; k++) begin
      idle(5);
      step(1, 2'd0, 32'hA500_0000, 4'h8);
    end
    // wrong key does nothing
    idle(2);
    step(1, 2'd0, 32'h5A00_0000, 4'h8);
    // R10: clearing enable alone is ignored
    cur_req = "R10";
    step(1, 2'd0, 32'h0000_8000, 4'h2);
    // R9: let it expire
    cur_req = "R9";
    idle(12);
    step(1, 2'd0, 32'h0000_0000, 4'h2);
    idle(4);

    // R10: disarm before expiry
    do_reset();
    cur_req = "R10";
    idle(4);
    step(1, 2'd1, 32'h0002_0004, 4'hF);
    step(1, 2'd0, 32'h0000_9000, 4'h2);
    idle(3);
    step(1, 2'd0, 32'h0000_0000, 4'h2);
    idle(20);

    finish_run();
  end
endmodule